// File: doc/BRIEF.md
# Dependency-Tracking Issue Window

This block sits between instruction decode and the execution groups of an out-of-order core. It takes in up to three decoded instructions per clock. Each instruction carries a read mask and a write mask over a shared resource space. That space holds the architectural registers and, as separate bits, each flag of the flags register. Every clock the window checks each waiting entry against all older entries that have not yet completed. From the entries with no conflict it sends the oldest, up to one per issue port, to the three execution groups. No renaming is done, so read-after-write, write-after-write and write-after-read conflicts all hold an entry back.

An execution group reports that it has finished by returning the entry's tag and a result on one of three completion ports. Completion can happen out of order and after any number of clocks. The window still retires entries strictly from its head, up to three per clock, and hands each tag and result to writeback. A retire group ends at the first entry that has not completed. The window is a circular buffer of `DEPTH` slots. The slot index serves as the tag.

Top module: `iw_window`

## Requirements
- R1: The resource space has `NREG+NFLAG` bits (16+4 by default). Bits 0 to NREG-1 are registers. Bits NREG and up are single flag bits, each compared on its own. A reader of flag bit 17 is not held back by a writer of flag bit 16. A reader of bit 16 is held back.
- R2: An entry that reads a resource written by an older, not yet completed entry is not issued. It may issue in the cycle after the clock edge at which the writer's completion is accepted.
- R3: An entry that writes a resource which an older, not yet completed entry reads or writes is also held back.
- R4: Each cycle, up to three ready entries are issued. The oldest in program order goes out on port 0, the next on port 1, then port 2. Ports fill from 0 with no gaps, and every entry is issued exactly once.
- R5: `in_ready` is high exactly when the number of free slots is at least the number of lanes set in `in_valid`. When it is low, no lane is accepted. Accepted lanes take consecutive tags in lane order. The tag is the slot index, counting up from 0 and wrapping at DEPTH. Slots retiring in the current cycle are not counted as free.
- R6: A completion marks the tagged entry done and stores its result. The same result is reported when the entry retires.
- R7: Retirement is in program order, up to three per cycle on retire lanes 0 upward. The group stops at the first entry that is not done, so completed younger entries wait behind it.
- R8: A new entry with no conflict issues in the cycle after it is accepted. A done entry at the head retires in the cycle after its completion is accepted.
- R9: While `rst_n` is low at a clock edge, the window is emptied. Afterwards nothing issues or retires, `in_ready` is high, and tags start again from 0.
- R10: With the default DEPTH of 48, exactly 48 entries can be in flight at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 3 | One bit per allocation lane |
| in_rd | input | 3 x NRES | Read resource mask per lane |
| in_wr | input | 3 x NRES | Write resource mask per lane |
| in_op | input | 3 x OP_W | Opaque operation payload per lane |
| in_ready | output | 1 | All offered lanes are accepted this cycle |
| iss_valid | output | 3 | An entry is sent on this issue port |
| iss_tag | output | 3 x TAG_W | Tag of the issued entry |
| iss_op | output | 3 x OP_W | Payload of the issued entry |
| cmp_valid | input | 3 | A completion is returned on this port |
| cmp_tag | input | 3 x TAG_W | Tag of the completed entry |
| cmp_data | input | 3 x DATA_W | Result of the completed entry |
| ret_valid | output | 3 | An entry retires on this lane |
| ret_tag | output | 3 x TAG_W | Tag of the retiring entry |
| ret_data | output | 3 x DATA_W | Result of the retiring entry |

## Verification
Allocation and retirement can fall in the same cycle. The bench fills the window to one slot short of full and completes the two oldest entries. In the cycle where those two retire, it offers a new lane. The offer must be accepted against the single free slot. The later occupancy must then show that two slots were freed and one was taken: a three-lane offer stalls and a two-lane offer fits. A second case checks the other direction. With the window full, an offer is refused even in the cycle a head entry retires. The scoreboard checks every retired tag and result against the order in which entries were offered.

// File: rtl/iw_pkg.sv
// Package: shared helpers for the issue window.
// Assumes all indices are below the window depth.
package iw_pkg;

    // Reduce a sum of two slot indices back into the ring.
    function automatic int iw_wrap(input int x, input int depth);
        return (x >= depth) ? x - depth : x;
    endfunction

    // Distance of a slot from the head, i.e. its age rank (0 = oldest).
    function automatic int iw_age(input int idx, input int head, input int depth);
        return (idx >= head) ? idx - head : idx + depth - head;
    endfunction

endpackage

// File: rtl/iw_hazard.sv
// Module: iw_hazard
// Compares the resource masks of every entry with those of every older,
// still uncompleted entry and flags the entries that must wait.
// Assumes: 'live' is valid and not yet done; age rank is taken from 'head'.
module iw_hazard import iw_pkg::*; #(
    parameter  int DEPTH = 48,
    parameter  int NRES  = 20,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [TAG_W-1:0]           head,
    input  logic [DEPTH-1:0]           live,
    input  logic [DEPTH-1:0][NRES-1:0] rd_mask,
    input  logic [DEPTH-1:0][NRES-1:0] wr_mask,
    output logic [DEPTH-1:0]           blocked
);

    logic [DEPTH-1:0][TAG_W-1:0] age;

    // Age rank of every slot relative to the head pointer.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            age[i] = TAG_W'(iw_age(i, int'(head), DEPTH));
        end
    end

    // Read-after-write, write-after-write and write-after-read checks.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (live[j] && (age[j] < age[i]) &&
                    (((wr_mask[j] & (rd_mask[i] | wr_mask[i])) != '0) ||
                     ((rd_mask[j] & wr_mask[i]) != '0))) begin
                    blocked[i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/iw_pick.sv
// Module: iw_pick
// Walks the ring from the head and selects the first WAYS candidates,
// oldest on output 0.
// Assumes: 'cand' already excludes empty, issued and blocked slots.
module iw_pick import iw_pkg::*; #(
    parameter  int DEPTH = 48,
    parameter  int WAYS  = 3,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TAG_W-1:0]           head,
    input  logic [DEPTH-1:0]           cand,
    output logic [WAYS-1:0]            sel_valid,
    output logic [WAYS-1:0][TAG_W-1:0] sel_idx
);

    // Oldest-first selection of up to WAYS candidates.
    always_comb begin
        int n;
        int s;
        n         = 0;
        sel_valid = '0;
        sel_idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            s = iw_wrap(int'(head) + k, DEPTH);
            if (cand[s] && (n < WAYS)) begin
                sel_valid[n] = 1'b1;
                sel_idx[n]   = TAG_W'(s);
                n            = n + 1;
            end
        end
    end

    // R4: no two ports carry the same entry in one cycle.
    for (genvar a = 0; a < WAYS; a++) begin : g_pa
        for (genvar b = a + 1; b < WAYS; b++) begin : g_pb
            a_r4_distinct: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_valid[a] && sel_valid[b]) |-> (sel_idx[a] != sel_idx[b]));
        end
    end

endmodule

// File: rtl/iw_window.sv
// Module: iw_window (top)
// Circular issue window with resource-mask scoreboard: allocates up to
// WAYS entries per clock, issues the oldest conflict-free entries, records
// completions and retires in program order.
// Assumes: completions name issued, live tags only; execution groups
// always accept what is issued.
module iw_window import iw_pkg::*; #(
    parameter  int DEPTH  = 48,
    parameter  int NREG   = 16,
    parameter  int NFLAG  = 4,
    parameter  int WAYS   = 3,
    parameter  int OP_W   = 8,
    parameter  int DATA_W = 16,
    localparam int NRES   = NREG + NFLAG,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             in_valid,
    input  logic [WAYS-1:0][NRES-1:0]   in_rd,
    input  logic [WAYS-1:0][NRES-1:0]   in_wr,
    input  logic [WAYS-1:0][OP_W-1:0]   in_op,
    output logic                        in_ready,
    output logic [WAYS-1:0]             iss_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  iss_tag,
    output logic [WAYS-1:0][OP_W-1:0]   iss_op,
    input  logic [WAYS-1:0]             cmp_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  cmp_tag,
    input  logic [WAYS-1:0][DATA_W-1:0] cmp_data,
    output logic [WAYS-1:0]             ret_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  ret_tag,
    output logic [WAYS-1:0][DATA_W-1:0] ret_data
);

    logic [DEPTH-1:0]              st_v;
    logic [DEPTH-1:0]              st_iss;
    logic [DEPTH-1:0]              st_dn;
    logic [DEPTH-1:0][NRES-1:0]    st_rd;
    logic [DEPTH-1:0][NRES-1:0]    st_wr;
    logic [DEPTH-1:0][OP_W-1:0]    st_op;
    logic [DEPTH-1:0][DATA_W-1:0]  st_res;
    logic [TAG_W-1:0]              head;
    logic [TAG_W-1:0]              tail;
    logic [CNT_W-1:0]              count;

    logic [DEPTH-1:0]              blocked;
    logic [DEPTH-1:0]              cand;
    logic [WAYS-1:0]               alloc_we;
    logic [WAYS-1:0][TAG_W-1:0]    alloc_slot;
    logic [CNT_W-1:0]              n_acc;
    logic [CNT_W-1:0]              n_ret;

    // Accept only when every offered lane fits in the registered free space.
    assign in_ready = (DEPTH - int'(count)) >= $countones(in_valid);

    // Pack accepted lanes onto consecutive slots from the tail.
    always_comb begin
        int pos;
        pos        = 0;
        alloc_we   = '0;
        alloc_slot = '0;
        for (int k = 0; k < WAYS; k++) begin
            if (in_valid[k] && in_ready) begin
                alloc_we[k]   = 1'b1;
                alloc_slot[k] = TAG_W'(iw_wrap(int'(tail) + pos, DEPTH));
                pos           = pos + 1;
            end
        end
        n_acc = CNT_W'(pos);
    end

    iw_hazard #(.DEPTH(DEPTH), .NRES(NRES)) hazard_i (
        .head    (head),
        .live    (st_v & ~st_dn),
        .rd_mask (st_rd),
        .wr_mask (st_wr),
        .blocked (blocked)
    );

    // Entries eligible for issue this cycle.
    assign cand = st_v & ~st_iss & ~blocked;

    iw_pick #(.DEPTH(DEPTH), .WAYS(WAYS)) pick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .head      (head),
        .cand      (cand),
        .sel_valid (iss_valid),
        .sel_idx   (iss_tag)
    );

    // Payload of each issued entry.
    always_comb begin
        for (int k = 0; k < WAYS; k++) iss_op[k] = st_op[iss_tag[k]];
    end

    // In-order retire group from the head, ending at the first not-done entry.
    always_comb begin
        logic go;
        int   s;
        int   n;
        go        = 1'b1;
        n         = 0;
        ret_valid = '0;
        for (int k = 0; k < WAYS; k++) begin
            s           = iw_wrap(int'(head) + k, DEPTH);
            ret_tag[k]  = TAG_W'(s);
            ret_data[k] = st_res[s];
            if (go && st_v[s] && st_dn[s]) begin
                ret_valid[k] = 1'b1;
                n            = n + 1;
            end else begin
                go = 1'b0;
            end
        end
        n_ret = CNT_W'(n);
    end

    // Entry state, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_v   <= '0;
            st_iss <= '0;
            st_dn  <= '0;
            st_rd  <= '0;
            st_wr  <= '0;
            st_op  <= '0;
            st_res <= '0;
            head   <= '0;
            tail   <= '0;
            count  <= '0;
        end else begin
            for (int k = 0; k < WAYS; k++) begin
                if (ret_valid[k]) begin
                    st_v[ret_tag[k]]   <= 1'b0;
                    st_iss[ret_tag[k]] <= 1'b0;
                    st_dn[ret_tag[k]]  <= 1'b0;
                end
                if (alloc_we[k]) begin
                    st_v[alloc_slot[k]]   <= 1'b1;
                    st_iss[alloc_slot[k]] <= 1'b0;
                    st_dn[alloc_slot[k]]  <= 1'b0;
                    st_rd[alloc_slot[k]]  <= in_rd[k];
                    st_wr[alloc_slot[k]]  <= in_wr[k];
                    st_op[alloc_slot[k]]  <= in_op[k];
                end
                if (iss_valid[k]) st_iss[iss_tag[k]] <= 1'b1;
                if (cmp_valid[k] && st_v[cmp_tag[k]]) begin
                    st_dn[cmp_tag[k]]  <= 1'b1;
                    st_res[cmp_tag[k]] <= cmp_data[k];
                end
            end
            head  <= TAG_W'(iw_wrap(int'(head) + int'(n_ret), DEPTH));
            tail  <= TAG_W'(iw_wrap(int'(tail) + int'(n_acc), DEPTH));
            count <= count + n_acc - n_ret;
        end
    end

    // R5, R10: occupancy never exceeds the window depth.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    // R5: a full window refuses any offer.
    a_r5_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(count) == DEPTH) && (in_valid != '0)) |-> !in_ready);

    // R7: retiring moves the head.
    a_r7_head_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid[0] |=> (head != $past(head)));

    for (genvar k = 0; k < WAYS; k++) begin : g_chk
        // R4: an issued entry is marked so it cannot go out again.
        a_r4_issue_once: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k] |=> st_iss[$past(iss_tag[k])]);
        // R7: a retired slot is free on the next cycle.
        a_r7_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
            ret_valid[k] |=> !st_v[$past(ret_tag[k])]);
    end

endmodule

// File: tb/iw_window_tb_top.sv
// Bench: directed stimulus with a retirement scoreboard.
module iw_window_tb_top;

    localparam int DEPTH  = 48;
    localparam int NREG   = 16;
    localparam int NFLAG  = 4;
    localparam int NRES   = NREG + NFLAG;
    localparam int WAYS   = 3;
    localparam int OP_W   = 8;
    localparam int DATA_W = 16;
    localparam int TAG_W  = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [WAYS-1:0]             in_valid;
    logic [WAYS-1:0][NRES-1:0]   in_rd;
    logic [WAYS-1:0][NRES-1:0]   in_wr;
    logic [WAYS-1:0][OP_W-1:0]   in_op;
    logic                        in_ready;
    logic [WAYS-1:0]             iss_valid;
    logic [WAYS-1:0][TAG_W-1:0]  iss_tag;
    logic [WAYS-1:0][OP_W-1:0]   iss_op;
    logic [WAYS-1:0]             cmp_valid;
    logic [WAYS-1:0][TAG_W-1:0]  cmp_tag;
    logic [WAYS-1:0][DATA_W-1:0] cmp_data;
    logic [WAYS-1:0]             ret_valid;
    logic [WAYS-1:0][TAG_W-1:0]  ret_tag;
    logic [WAYS-1:0][DATA_W-1:0] ret_data;

    iw_window #(.DEPTH(DEPTH), .NREG(NREG), .NFLAG(NFLAG), .WAYS(WAYS),
                .OP_W(OP_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_rd(in_rd), .in_wr(in_wr), .in_op(in_op),
        .in_ready(in_ready),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data)
    );

    typedef struct { int tag; logic [DATA_W-1:0] data; } exp_t;

    exp_t              exp_q[$];
    int                open_q[$];
    logic [DATA_W-1:0] data_of [DEPTH];
    bit                seen_iss [DEPTH];
    int                next_tag = 0;
    int                seq = 0;
    int                nchk = 0;
    int                nfail = 0;
    bit                done_flag = 0;

    function automatic void chk(input bit ok, input string req, input string what,
                                input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endfunction

    function automatic logic [NRES-1:0] rb(input int i);
        return NRES'(1) << i;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        in_valid  = '0;
        cmp_valid = '0;
    endtask

    task automatic lane(input int k, input logic [NRES-1:0] rd, input logic [NRES-1:0] wr);
        in_rd[k] = rd;
        in_wr[k] = wr;
    endtask

    // Driver: offer n lanes, check in_ready, push expected retirements.
    task automatic offer(input int n, input bit want, input string req);
        bit ok;
        for (int k = 0; k < WAYS; k++) in_op[k] = OP_W'(seq + k);
        in_valid = WAYS'((1 << n) - 1);
        #1;
        ok = in_ready;
        chk(ok == want, req, "in_ready for offer", int'(ok), int'(want));
        if (ok) begin
            for (int k = 0; k < n; k++) begin
                exp_t e;
                e.tag  = next_tag;
                e.data = DATA_W'(16'hA5C3 ^ (seq * 37));
                data_of[next_tag]  = e.data;
                seen_iss[next_tag] = 1'b0;
                exp_q.push_back(e);
                open_q.push_back(next_tag);
                next_tag = (next_tag + 1) % DEPTH;
                seq++;
            end
        end
        tick();
    endtask

    task automatic complete(input int n, input int t0, input int t1, input int t2);
        int t[3];
        t = '{t0, t1, t2};
        for (int k = 0; k < n; k++) begin
            cmp_valid[k] = 1'b1;
            cmp_tag[k]   = TAG_W'(t[k]);
            cmp_data[k]  = data_of[t[k]];
            for (int i = 0; i < open_q.size(); i++) begin
                if (open_q[i] == t[k]) begin
                    open_q.delete(i);
                    break;
                end
            end
        end
        tick();
    endtask

    task automatic check_iss(input int n, input int t0, input int t1, input int t2,
                             input string req);
        int t[3];
        logic [WAYS-1:0] m;
        t = '{t0, t1, t2};
        m = WAYS'((1 << n) - 1);
        chk(iss_valid == m, req, "issue valid mask", int'(iss_valid), int'(m));
        for (int k = 0; k < n; k++)
            chk(int'(iss_tag[k]) == t[k], req, "issue tag", int'(iss_tag[k]), t[k]);
    endtask

    // Complete every open entry once it has been seen issuing.
    task automatic drain();
        while (open_q.size() > 0) begin
            int pk[3];
            int n;
            n = 0;
            for (int i = 0; i < open_q.size() && n < 3; i++) begin
                if (seen_iss[open_q[i]]) begin
                    pk[n] = open_q[i];
                    n++;
                end
            end
            if (n == 0) tick();
            else begin
                complete(n, pk[0], pk[1], pk[2]);
                tick();
            end
        end
        repeat (3) tick();
    endtask

    // Monitor: record issues and compare retirements against the queue.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            for (int k = 0; k < WAYS; k++) begin
                if (iss_valid[k]) begin
                    chk(!seen_iss[iss_tag[k]], "R4", "entry issued twice, tag",
                        int'(iss_tag[k]), -1);
                    seen_iss[iss_tag[k]] = 1'b1;
                end
            end
            for (int k = 0; k < WAYS; k++) begin
                if (ret_valid[k]) begin
                    if (k > 0)
                        chk(ret_valid[k-1], "R7", "retire lane gap", 0, 1);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "unexpected retire tag", int'(ret_tag[k]), -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(int'(ret_tag[k]) == e.tag, "R7", "retire order tag",
                            int'(ret_tag[k]), e.tag);
                        chk(ret_data[k] == e.data, "R6", "retire result",
                            int'(ret_data[k]), int'(e.data));
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "R4", "watchdog cycles", 50000, 0);
        finish_run();
    end

    initial begin
        in_valid = '0; in_rd = '0; in_wr = '0; in_op = '0;
        cmp_valid = '0; cmp_tag = '0; cmp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: empty after reset
        chk(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
        chk(iss_valid == '0, "R9", "no issue after reset", int'(iss_valid), 0);
        chk(ret_valid == '0, "R9", "no retire after reset", int'(ret_valid), 0);

        // R4/R5/R8: three independent entries, tags 0..2, issue next cycle
        lane(0, '0, rb(1)); lane(1, '0, rb(2)); lane(2, '0, rb(3));
        offer(3, 1, "R5");
        check_iss(3, 0, 1, 2, "R8");
        tick();
        check_iss(0, 0, 0, 0, "R4");

        // R2: RAW on r4; tag 4 waits for tag 3
        lane(0, '0, rb(4)); lane(1, rb(4), rb(5)); lane(2, '0, rb(6));
        offer(3, 1, "R5");
        check_iss(2, 3, 5, 0, "R2");
        tick();
        check_iss(0, 0, 0, 0, "R2");
        complete(1, 3, 0, 0);
        check_iss(1, 4, 0, 0, "R2");
        chk(ret_valid == '0, "R7", "head not done, no retire", int'(ret_valid), 0);

        // R7: out-of-order completion, in-order retirement
        complete(2, 2, 1, 0);
        chk(ret_valid == '0, "R7", "head still not done", int'(ret_valid), 0);
        complete(1, 0, 0, 0);
        chk(ret_valid == 3'b111, "R7", "three retire together", int'(ret_valid), 7);
        tick();
        chk(ret_valid == 3'b001, "R7", "group stops at incomplete", int'(ret_valid), 1);

        // R1: flag bits compared separately
        lane(0, '0, rb(16)); lane(1, rb(17), '0); lane(2, rb(16), '0);
        offer(3, 1, "R5");
        check_iss(2, 6, 7, 0, "R1");

        // R3: WAR on r7 and WAW on r8
        lane(0, rb(7), '0); lane(1, '0, rb(7)); lane(2, '0, rb(8));
        offer(3, 1, "R5");
        check_iss(2, 9, 11, 0, "R3");
        lane(0, '0, rb(8));
        offer(1, 1, "R5");
        check_iss(0, 0, 0, 0, "R3");
        complete(1, 9, 0, 0);
        check_iss(1, 10, 0, 0, "R3");
        drain();

        // R4: five readers released at once, oldest first
        lane(0, '0, rb(9)); lane(1, rb(9), '0); lane(2, rb(9), '0);
        offer(3, 1, "R5");
        check_iss(1, 13, 0, 0, "R2");
        lane(0, rb(9), '0); lane(1, rb(9), '0); lane(2, rb(9), '0);
        offer(3, 1, "R5");
        check_iss(0, 0, 0, 0, "R2");
        complete(1, 13, 0, 0);
        check_iss(3, 14, 15, 16, "R4");
        tick();
        check_iss(2, 17, 18, 0, "R4");
        drain();

        // R5/R10: fill the window, tags wrap past DEPTH
        lane(0, '0, '0); lane(1, '0, '0); lane(2, '0, '0);
        for (int i = 0; i < 15; i++) offer(3, 1, "R5");
        offer(1, 1, "R5");
        offer(3, 0, "R5");
        offer(2, 1, "R5");
        offer(1, 0, "R10");
        complete(1, 19, 0, 0);
        offer(1, 0, "R5");
        complete(2, 20, 21, 0);
        offer(1, 1, "R5");
        offer(3, 0, "R5");
        offer(2, 1, "R5");
        offer(1, 0, "R10");
        drain();

        // R9: reset with entries in flight
        lane(0, '0, rb(2)); lane(1, '0, rb(3)); lane(2, '0, rb(4));
        offer(3, 1, "R5");
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #1;
        chk(iss_valid == '0, "R9", "no issue after mid-run reset", int'(iss_valid), 0);
        chk(ret_valid == '0, "R9", "no retire after mid-run reset", int'(ret_valid), 0);
        exp_q.delete();
        open_q.delete();
        next_tag = 0;
        offer(3, 1, "R9");
        check_iss(3, 0, 1, 2, "R9");
        drain();

        finish_run();
    end

endmodule